// File: doc/BRIEF.md
# Bayer Raster Position and Colour Tagger

This block follows a raw sensor image as it streams in one pixel at a time. A pixel-valid strobe advances column and row counters, and a frame-start strobe returns them to the origin. Each accepted pixel comes out one cycle later with its column, its row and a two-bit Bayer colour code. The outputs also carry end-of-line and end-of-frame markers and a flag for the last three line times of the frame. Downstream statistics logic can use those three line times to append its summary data.

Software sets the line length, the frame height, two phase bits and a summary-enable bit. The two phase bits flip the column parity and the row parity independently, so any of the four corners of the filter mosaic can be the first pixel. These settings are sampled only when a frame starts. A configuration-error output is raised when summary mode is enabled but the line is too short to carry the 1728-clock summary payload (864 cells of 4 elements, 2 elements per clock) over three lines. That sets the minimum at 576 pixels per line.

Top module: `bayer_pos_tagger`

## Requirements
- R1: After reset, out_valid, eol, eof, tail_win and cfg_err are 0, and col and row are 0.
- R2: A pixel accepted with pix_valid=1 at clock edge N appears at the outputs after edge N+1, with out_valid=1 and the pixel's col/row. The position advances only on accepted pixels, and out_valid is 0 in any cycle that follows a cycle without pix_valid.
- R3: The column runs from 0 to pixels-per-line minus 1. The pixel at the last column has eol=1, and the next pixel goes to column 0 of the following row.
- R4: The last pixel of row lines-per-frame minus 1 has eof=1 (together with eol), and the next pixel goes to column 0, row 0.
- R5: frame_start returns the position to the origin. A pixel accepted in the same cycle as frame_start is pixel (0,0).
- R6: color = {row[0] XOR start_line, col[0] XOR start_pix}, with the codes 00=Gr, 01=R, 10=B and 11=Gb.
- R7: With both phase bits at 0, pixel (0,0) is Gr (00), pixel (1,0) is R (01), pixel (0,1) is B (10) and pixel (1,1) is Gb (11).
- R8: tail_win is 1 for a pixel whose row is at least lines-per-frame minus 3. When lines-per-frame is 3 or less, it is 1 for every row.
- R9: cfg_err is 1 exactly when the settings latched at the last frame start have summary enabled and pixels-per-line below 576. It updates in the cycle after frame_start.
- R10: Changes to the configuration inputs between frame starts have no effect on positions, colours, flags or cfg_err until the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ppl | input | COL_W | Pixels per line |
| cfg_lpf | input | ROW_W | Lines per frame |
| cfg_start_pix | input | 1 | Column phase bit |
| cfg_start_line | input | 1 | Row phase bit |
| cfg_summary_en | input | 1 | Summary mode enable |
| frame_start | input | 1 | Start-of-frame strobe |
| pix_valid | input | 1 | Pixel accepted this cycle |
| out_valid | output | 1 | Tag outputs describe an accepted pixel |
| col | output | COL_W | Column of the tagged pixel |
| row | output | ROW_W | Row of the tagged pixel |
| color | output | 2 | Bayer code: 00 Gr, 01 R, 10 B, 11 Gb |
| eol | output | 1 | Last pixel of a line |
| eof | output | 1 | Last pixel of a frame |
| tail_win | output | 1 | Pixel lies in the last three line times |
| cfg_err | output | 1 | Summary enabled with too short a line |

## Verification
The bench walks complete small frames and leaves gaps in pix_valid. A design that counted clocks instead of accepted pixels would drift away from the expected columns. It applies every phase-bit combination and checks the colours, which would catch swapped parity bits or a lost inversion. It also aims pix_valid into the same cycle as frame_start, restarts a frame part way through, and changes the configuration in mid-frame. A design that dropped that first pixel, or applied settings at once, would tag the wrong position or flag the wrong error. Frames of two lines and line lengths of 575 and 576 test the tail-window underflow and the error threshold.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    typedef enum logic [1:0] {
        CLR_GR = 2'b00,
        CLR_R  = 2'b01,
        CLR_B  = 2'b10,
        CLR_GB = 2'b11
    } bayer_clr_e;
endpackage

// File: rtl/bpt_cfg_shadow.sv
module bpt_cfg_shadow #(
    parameter int COL_W   = 12,
    parameter int ROW_W   = 12,
    parameter int DEF_PPL = 640,
    parameter int DEF_LPF = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [COL_W-1:0] in_ppl,
    input  logic [ROW_W-1:0] in_lpf,
    input  logic             in_sp,
    input  logic             in_sl,
    input  logic             in_sum,
    output logic [COL_W-1:0] sh_ppl,
    output logic [ROW_W-1:0] sh_lpf,
    output logic             sh_sp,
    output logic             sh_sl,
    output logic             sh_sum,
    output logic [COL_W-1:0] act_ppl,
    output logic [ROW_W-1:0] act_lpf,
    output logic             act_sp,
    output logic             act_sl
);
    typedef struct packed {
        logic [COL_W-1:0] ppl;
        logic [ROW_W-1:0] lpf;
        logic             sp;
        logic             sl;
        logic             sum;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.ppl = in_ppl;
            st_d.lpf = in_lpf;
            st_d.sp  = in_sp;
            st_d.sl  = in_sl;
            st_d.sum = in_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ppl <= COL_W'(DEF_PPL);
            st_q.lpf <= ROW_W'(DEF_LPF);
            st_q.sp  <= 1'b0;
            st_q.sl  <= 1'b0;
            st_q.sum <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_ppl  = st_q.ppl;
    assign sh_lpf  = st_q.lpf;
    assign sh_sp   = st_q.sp;
    assign sh_sl   = st_q.sl;
    assign sh_sum  = st_q.sum;
    // the cycle carrying frame_start already runs on the new settings
    assign act_ppl = frame_start ? in_ppl : st_q.ppl;
    assign act_lpf = frame_start ? in_lpf : st_q.lpf;
    assign act_sp  = frame_start ? in_sp  : st_q.sp;
    assign act_sl  = frame_start ? in_sl  : st_q.sl;
endmodule

// File: rtl/bpt_raster_cnt.sv
module bpt_raster_cnt #(
    parameter int COL_W = 12,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [COL_W-1:0] ppl,
    input  logic [ROW_W-1:0] lpf,
    output logic [COL_W-1:0] pos_col,
    output logic [ROW_W-1:0] pos_row,
    output logic             last_col,
    output logic             last_row
);
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } pos_t;

    pos_t cnt_d, cnt_q;

    assign pos_col  = frame_start ? '0 : cnt_q.col;
    assign pos_row  = frame_start ? '0 : cnt_q.row;
    assign last_col = (pos_col == ppl - COL_W'(1));
    assign last_row = (pos_row == lpf - ROW_W'(1));

    always_comb begin
        cnt_d.col = pos_col;
        cnt_d.row = pos_row;
        if (pix_valid) begin
            if (last_col) begin
                cnt_d.col = '0;
                cnt_d.row = last_row ? '0 : pos_row + ROW_W'(1);
            end else begin
                cnt_d.col = pos_col + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bpt_color_map.sv
module bpt_color_map (
    input  logic       col_lsb,
    input  logic       row_lsb,
    input  logic       start_pix,
    input  logic       start_line,
    output logic [1:0] color
);
    import bpt_pkg::*;
    bayer_clr_e clr;

    always_comb begin
        unique case ({row_lsb ^ start_line, col_lsb ^ start_pix})
            2'b00:   clr = CLR_GR;
            2'b01:   clr = CLR_R;
            2'b10:   clr = CLR_B;
            default: clr = CLR_GB;
        endcase
    end

    assign color = clr;
endmodule

// File: rtl/bayer_pos_tagger.sv
module bayer_pos_tagger #(
    parameter int COL_W       = 12,
    parameter int ROW_W       = 12,
    parameter int DEF_PPL     = 640,
    parameter int DEF_LPF     = 480,
    parameter int SUM_CELLS   = 864,
    parameter int SUM_ELEMS   = 4,
    parameter int SUM_PER_CLK = 2,
    parameter int TAIL_LINES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] cfg_ppl,
    input  logic [ROW_W-1:0] cfg_lpf,
    input  logic             cfg_start_pix,
    input  logic             cfg_start_line,
    input  logic             cfg_summary_en,
    input  logic             frame_start,
    input  logic             pix_valid,
    output logic             out_valid,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic [1:0]       color,
    output logic             eol,
    output logic             eof,
    output logic             tail_win,
    output logic             cfg_err
);
    localparam int SUM_CLKS = SUM_CELLS * SUM_ELEMS / SUM_PER_CLK;
    localparam int MIN_PPL  = (SUM_CLKS + TAIL_LINES - 1) / TAIL_LINES;

    logic [COL_W-1:0] sh_ppl, act_ppl, pos_col;
    logic [ROW_W-1:0] sh_lpf, act_lpf, pos_row;
    logic             sh_sp, sh_sl, sh_sum, act_sp, act_sl;
    logic             last_col, last_row;
    logic [1:0]       clr_w;
    logic             tail_w;

    bpt_cfg_shadow #(.COL_W(COL_W), .ROW_W(ROW_W), .DEF_PPL(DEF_PPL), .DEF_LPF(DEF_LPF)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_ppl(cfg_ppl), .in_lpf(cfg_lpf), .in_sp(cfg_start_pix),
        .in_sl(cfg_start_line), .in_sum(cfg_summary_en),
        .sh_ppl(sh_ppl), .sh_lpf(sh_lpf), .sh_sp(sh_sp), .sh_sl(sh_sl), .sh_sum(sh_sum),
        .act_ppl(act_ppl), .act_lpf(act_lpf), .act_sp(act_sp), .act_sl(act_sl)
    );

    bpt_raster_cnt #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
        .ppl(act_ppl), .lpf(act_lpf), .pos_col(pos_col), .pos_row(pos_row),
        .last_col(last_col), .last_row(last_row)
    );

    bpt_color_map u_map (
        .col_lsb(pos_col[0]), .row_lsb(pos_row[0]),
        .start_pix(act_sp), .start_line(act_sl), .color(clr_w)
    );

    // widened compare avoids underflow of lpf-3 on short frames
    assign tail_w = ({1'b0, pos_row} + (ROW_W+1)'(TAIL_LINES)) >= {1'b0, act_lpf};

    typedef struct packed {
        logic             vld;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [1:0]       clr;
        logic             eol;
        logic             eof;
        logic             tail;
        logic             err;
    } tag_t;

    tag_t tag_d, tag_q;

    always_comb begin
        tag_d     = tag_q;
        tag_d.vld = pix_valid;
        tag_d.eol = 1'b0;
        tag_d.eof = 1'b0;
        if (pix_valid) begin
            tag_d.col  = pos_col;
            tag_d.row  = pos_row;
            tag_d.clr  = clr_w;
            tag_d.eol  = last_col;
            tag_d.eof  = last_col && last_row;
            tag_d.tail = tail_w;
        end
        if (frame_start)
            tag_d.err = cfg_summary_en && ({1'b0, cfg_ppl} < (COL_W+1)'(MIN_PPL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign out_valid = tag_q.vld;
    assign col       = tag_q.col;
    assign row       = tag_q.row;
    assign color     = tag_q.clr;
    assign eol       = tag_q.eol;
    assign eof       = tag_q.eof;
    assign tail_win  = tag_q.tail;
    assign cfg_err   = tag_q.err;
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
    parameter int COL_W = 12,
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             out_valid,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic [1:0]       color,
    input logic             eol,
    input logic             eof,
    input logic [COL_W-1:0] sh_ppl,
    input logic             sh_sp,
    input logic             sh_sl
);
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    // R4
    eof_with_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> eol && out_valid);
    // R3
    eol_last_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol |-> col == sh_ppl - COL_W'(1));
    // R6
    color_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> color == {row[0] ^ sh_sl, col[0] ^ sh_sp});
endmodule

bind bayer_pos_tagger bpt_checker #(.COL_W(COL_W), .ROW_W(ROW_W)) u_bpt_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .out_valid(out_valid),
    .col(col), .row(row), .color(color), .eol(eol), .eof(eof),
    .sh_ppl(sh_ppl), .sh_sp(sh_sp), .sh_sl(sh_sl)
);

// File: tb/tb_bayer_pos_tagger.sv
module tb_bayer_pos_tagger;
    localparam int COL_W = 12;
    localparam int ROW_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [COL_W-1:0] cfg_ppl = 12'd4;
    logic [ROW_W-1:0] cfg_lpf = 12'd6;
    logic             cfg_start_pix = 1'b0;
    logic             cfg_start_line = 1'b0;
    logic             cfg_summary_en = 1'b0;
    logic             frame_start = 1'b0;
    logic             pix_valid = 1'b0;
    logic             out_valid, eol, eof, tail_win, cfg_err;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [1:0]       color;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side model of the latched settings and position
    int m_ppl, m_lpf, m_col, m_row;
    bit m_sp, m_sl;

    always #5 clk = ~clk;

    bayer_pos_tagger #(.COL_W(COL_W), .ROW_W(ROW_W)) dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle at negedge, then check at next negedge
    task automatic step(input bit fs, input bit pv, input string req);
        int ec, er;
        bit last_c, last_r;
        frame_start = fs;
        pix_valid   = pv;
        if (fs) begin
            m_ppl = int'(cfg_ppl); m_lpf = int'(cfg_lpf);
            m_sp = cfg_start_pix; m_sl = cfg_start_line;
            m_col = 0; m_row = 0;
        end
        ec = m_col; er = m_row;
        last_c = (ec == m_ppl - 1);
        last_r = (er == m_lpf - 1);
        if (pv) begin
            if (last_c) begin
                m_col = 0;
                m_row = last_r ? 0 : m_row + 1;
            end else m_col = m_col + 1;
        end
        @(negedge clk);
        frame_start = 1'b0;
        pix_valid   = 1'b0;
        chk(req, "out_valid", int'(out_valid), int'(pv));
        if (pv) begin
            chk(req, "col", int'(col), ec);
            chk(req, "row", int'(row), er);
            chk("R6", "color", int'(color), int'({(er % 2 == 1) ^ m_sl, (ec % 2 == 1) ^ m_sp}));
            chk("R3", "eol", int'(eol), int'(last_c));
            chk("R4", "eof", int'(eof), int'(last_c && last_r));
            chk("R8", "tail_win", int'(tail_win), int'(er + 3 >= m_lpf));
        end
    endtask

    task automatic t_reset;
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "col", int'(col), 0);
        chk("R1", "row", int'(row), 0);
        chk("R1", "eol", int'(eol), 0);
        chk("R1", "eof", int'(eof), 0);
        chk("R1", "tail_win", int'(tail_win), 0);
        chk("R1", "cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_full_frame;
        cfg_ppl = 12'd4; cfg_lpf = 12'd6; cfg_start_pix = 0; cfg_start_line = 0;
        step(1'b1, 1'b1, "R5");
        chk("R7", "first Gr", int'(color), 0);
        step(1'b0, 1'b1, "R2");
        chk("R7", "second R", int'(color), 1);
        for (int i = 2; i < 24; i++) begin
            step(1'b0, 1'b1, "R3");
            if (i == 4) chk("R7", "row1 col0 B", int'(color), 2);
            if (i == 5) chk("R7", "row1 col1 Gb", int'(color), 3);
        end
        chk("R4", "eof at frame end", int'(eof), 1);
        step(1'b0, 1'b1, "R4");
        chk("R4", "wrap row", int'(row), 0);
    endtask

    task automatic t_gaps;
        step(1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, "R2");
        step(1'b0, 1'b1, "R2");
        chk("R2", "col after gap", int'(col), 1);
    endtask

    task automatic t_phases;
        for (int p = 1; p < 4; p++) begin
            cfg_start_pix = p[0]; cfg_start_line = p[1];
            step(1'b1, 1'b1, "R6");
            step(1'b0, 1'b1, "R6");
            for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R6");
        end
        cfg_start_pix = 0; cfg_start_line = 0;
    endtask

    task automatic t_restart;
        step(1'b1, 1'b1, "R5");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        chk("R5", "restart col", int'(col), 0);
        chk("R5", "restart row", int'(row), 0);
    endtask

    task automatic t_midframe_cfg;
        cfg_ppl = 12'd4; cfg_lpf = 12'd6; cfg_start_pix = 0;
        step(1'b1, 1'b1, "R10");
        cfg_ppl = 12'd2; cfg_lpf = 12'd3; cfg_start_pix = 1; cfg_summary_en = 1;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R10");
        chk("R10", "col held to old length", int'(col), 1);
        chk("R10", "cfg_err before frame start", int'(cfg_err), 0);
        cfg_ppl = 12'd4; cfg_lpf = 12'd6; cfg_start_pix = 0; cfg_summary_en = 0;
    endtask

    task automatic t_short_frame;
        cfg_ppl = 12'd3; cfg_lpf = 12'd2;
        step(1'b1, 1'b1, "R8");
        chk("R8", "tail on row0 of 2-line frame", int'(tail_win), 1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R8");
        cfg_ppl = 12'd4; cfg_lpf = 12'd6;
        step(1'b1, 1'b1, "R8");
        chk("R8", "no tail on row0 of 6-line frame", int'(tail_win), 0);
    endtask

    task automatic t_cfg_err;
        cfg_summary_en = 1; cfg_ppl = 12'd575;
        step(1'b1, 1'b0, "R9");
        chk("R9", "cfg_err at 575", int'(cfg_err), 1);
        cfg_ppl = 12'd576;
        step(1'b0, 1'b0, "R9");
        chk("R9", "cfg_err held until frame start", int'(cfg_err), 1);
        step(1'b1, 1'b0, "R9");
        chk("R9", "cfg_err at 576", int'(cfg_err), 0);
        cfg_summary_en = 0; cfg_ppl = 12'd100;
        step(1'b1, 1'b0, "R9");
        chk("R9", "cfg_err summary off", int'(cfg_err), 0);
        cfg_ppl = 12'd4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_frame();
        t_gaps();
        t_phases();
        t_restart();
        t_midframe_cfg();
        t_short_frame();
        t_cfg_err();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule